// File: doc/BRIEF.md
# Bus Ready Synchronizer with Wait-State Inserter

This block builds the ready line that a processor samples to decide whether to stretch a bus cycle. It has two ready sources, each qualified by its own active-low enable. The block merges them and retimes the result so that the output only moves on the falling clock edge. The processor samples on the rising edge, so its setup window is protected. A strap input chooses between one register stage and two register stages of synchronization, traded against latency.

A programmable wait inserter sits in front of the first ready source. While an active-low device select is held, a zero walks along a chain of registers that reloads to all ones between cycles. A tap chosen by a 3-bit count holds the first source's contribution low for exactly that many clock periods after the select falls. A count of zero inserts nothing. The second source is never affected by the inserter.

Top module: `ready_sync_top`

## Requirements
- R1: While `rst_n` is low, `ready_out` is driven low at the next falling edge, and the wait chain returns to all ones.
- R2: Source A (`rdy_a`) contributes a high only while `en_a_n` is 0; with `en_a_n` at 1 its level has no effect on `ready_out`.
- R3: Source B (`rdy_b`) contributes a high only while `en_b_n` is 0; with `en_b_n` at 1 its level has no effect on `ready_out`.
- R4: The merged ready level is the OR of the two qualified sources.
- R5: With `two_stage` = 0, the merged level of a clock period appears on `ready_out` at the falling edge inside that same period.
- R6: With `two_stage` = 1, the merged level is first registered on a rising edge and reaches `ready_out` at the following falling edge, one period later than with `two_stage` = 0.
- R7: `ready_out` never changes on a rising clock edge.
- R8: With `wait_cnt` = N (1 to 7), source A is suppressed during the first N clock periods in which `dev_sel_n` is 0, counted from the period in which it fell. From period N+1 onward, source A passes again.
- R9: With `wait_cnt` = 0, the select never suppresses source A.
- R10: A period with `dev_sel_n` = 1 reloads the wait chain, so the next selection counts its waits again from the start.
- R11: The wait inserter never suppresses source B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock; sampling happens on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rdy_a | input | 1 | Ready source A, subject to wait insertion |
| en_a_n | input | 1 | Active-low qualifier for source A |
| rdy_b | input | 1 | Ready source B |
| en_b_n | input | 1 | Active-low qualifier for source B |
| two_stage | input | 1 | 1 selects two synchronizer stages, 0 selects one |
| dev_sel_n | input | 1 | Active-low device select that opens a wait count |
| wait_cnt | input | 3 | Number of wait periods to insert, 0 to 7 |
| ready_out | output | 1 | Retimed ready level, changes on the falling edge |

## Verification
Wait insertion on source A can fall in the same period as an enabled, high source B. The OR must then keep `ready_out` high while the counter is still running. The bench provokes this by selecting a device with a nonzero count while source B is enabled. Partway through the count it drops source B, so that the suppression shows up for the remaining periods only. A behavioural model compares every period in both stage modes: it counts selected periods with an integer and delays the merged level by one period.

// File: rtl/ready_sync_pkg.sv
// Package: shared sizing for the ready synchronizer.
// Assumes wait counts are small (a few bits); the chain length follows.
package ready_sync_pkg;
    parameter int unsigned WAIT_CNT_W = 3;
    localparam int unsigned MAX_WAITS = (1 << WAIT_CNT_W) - 1;
    typedef logic [WAIT_CNT_W-1:0] wait_cnt_t;
endpackage

// File: rtl/ws_shifter.sv
// Wait-state shifter: a zero walks one place per clock along a chain of
// MAX_WAITS registers while the select is low. The tap chosen by the count
// gives the hold signal. Assumes the select is already synchronous to clk.
module ws_shifter #(
    parameter int unsigned CNT_W = 3,
    localparam int unsigned CHAIN = (1 << CNT_W) - 1,
    localparam int unsigned TAPS  = 1 << CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_n,
    input  logic [CNT_W-1:0] count,
    output logic             hold_a
);
    logic [CHAIN-1:0] walk_q;
    logic [TAPS-1:0]  tap_vec;

    // Chain: reload ones when idle, otherwise shift a zero in at bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)     walk_q <= '1;
        else if (sel_n) walk_q <= '1;
        else            walk_q <= {walk_q[CHAIN-2:0], 1'b0};
    end

    // Tap table: a count of zero maps to a constant "no hold".
    assign tap_vec[0] = 1'b0;
    generate
        for (genvar i = 1; i < TAPS; i++) begin : g_tap
            assign tap_vec[i] = walk_q[i-1];
        end
    endgenerate

    // Hold source A while selected and the zero has not reached the tap.
    assign hold_a = !sel_n && tap_vec[count];
endmodule

// File: rtl/ready_combine.sv
// Ready combiner: qualifies each source by its active-low enable, applies
// the wait hold to source A only, and ORs the two results.
module ready_combine (
    input  logic rdy_a,
    input  logic en_a_n,
    input  logic hold_a,
    input  logic rdy_b,
    input  logic en_b_n,
    output logic merged
);
    logic qual_a, qual_b;

    // Qualification and merge.
    always_comb begin
        qual_a = rdy_a && !en_a_n && !hold_a;
        qual_b = rdy_b && !en_b_n;
        merged = qual_a || qual_b;
    end
endmodule

// File: rtl/ready_stage.sv
// Ready retiming: an optional rising-edge stage, then a falling-edge output
// register, so the output only moves half a period before the rising-edge
// sample. Assumes rst_n is held at least across one falling edge.
module ready_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic two_stage,
    input  logic merged,
    output logic ready
);
    logic first_q;
    logic pick;

    // First stage on the rising edge (used only in two-stage mode).
    always_ff @(posedge clk) begin
        if (!rst_n) first_q <= 1'b0;
        else        first_q <= merged;
    end

    // Stage-count select.
    always_comb pick = two_stage ? first_q : merged;

    // Output register on the falling edge.
    always_ff @(negedge clk) begin
        if (!rst_n) ready <= 1'b0;
        else        ready <= pick;
    end
endmodule

// File: rtl/ready_sync_top.sv
// Top: wait-state shifter, source combiner and retiming stage.
// Assumes every input is synchronous to clk except where the two-stage
// option is chosen for a ready source that is not.
module ready_sync_top
    import ready_sync_pkg::*;
#(
    parameter int unsigned CNT_W = WAIT_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rdy_a,
    input  logic             en_a_n,
    input  logic             rdy_b,
    input  logic             en_b_n,
    input  logic             two_stage,
    input  logic             dev_sel_n,
    input  logic [CNT_W-1:0] wait_cnt,
    output logic             ready_out
);
    logic hold_a;
    logic merged;

    ws_shifter #(.CNT_W(CNT_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .sel_n(dev_sel_n),
        .count(wait_cnt), .hold_a(hold_a)
    );

    ready_combine u_comb (
        .rdy_a(rdy_a), .en_a_n(en_a_n), .hold_a(hold_a),
        .rdy_b(rdy_b), .en_b_n(en_b_n), .merged(merged)
    );

    ready_stage u_stage (
        .clk(clk), .rst_n(rst_n), .two_stage(two_stage),
        .merged(merged), .ready(ready_out)
    );
endmodule

// File: rtl/ready_sync_checks.sv
// Checker for ready_sync_top, bound to every instance. All properties are
// sampled on the rising edge, where ready_out holds its falling-edge value.
module ready_sync_checks #(
    parameter int unsigned CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rdy_a,
    input logic             en_a_n,
    input logic             rdy_b,
    input logic             en_b_n,
    input logic             two_stage,
    input logic             dev_sel_n,
    input logic [CNT_W-1:0] wait_cnt,
    input logic             ready_out
);
    logic armed = 1'b0;

    // Arm the edge check after the first reset release.
    always @(posedge clk) if (rst_n) armed <= 1'b1;

    // R7: output moves only while clk is low (falling-edge register).
    always @(ready_out) begin
        if (armed) assert_fall_edge_only_R7: assert (clk == 1'b0);
    end

    // R2, R3: no enabled source for two periods gives a low output.
    assert_no_source_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_a_n && en_b_n && $past(en_a_n && en_b_n)) |-> !ready_out);

    // R8: first selected period with a nonzero count and only A possible.
    assert_first_wait_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dev_sel_n) && wait_cnt != '0 && en_b_n && !two_stage) |-> !ready_out);

    // R9: count 0 lets source A straight through in one-stage mode.
    assert_zero_count_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_a && !en_a_n && wait_cnt == '0 && !two_stage) |-> ready_out);

    // R6, R11: in two-stage mode, an enabled high B last period shows now.
    assert_two_stage_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (two_stage && $past(rst_n) && $past(rdy_b && !en_b_n)) |-> ready_out);

    // R5: one-stage mode, enabled high B is visible in the same period.
    assert_one_stage_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!two_stage && rdy_b && !en_b_n) |-> ready_out);
endmodule

bind ready_sync_top ready_sync_checks #(.CNT_W(CNT_W)) u_checks (
    .clk(clk), .rst_n(rst_n), .rdy_a(rdy_a), .en_a_n(en_a_n),
    .rdy_b(rdy_b), .en_b_n(en_b_n), .two_stage(two_stage),
    .dev_sel_n(dev_sel_n), .wait_cnt(wait_cnt), .ready_out(ready_out)
);

// File: tb/ready_sync_top_tb_top.sv
// Bench: a behavioural model (integer select counter, one-period delay of
// the merged level) compared in every period, plus an R7 stability probe.
module ready_sync_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rdy_a = 1'b0, en_a_n = 1'b1, rdy_b = 1'b0, en_b_n = 1'b1;
    logic       two_stage = 1'b0, dev_sel_n = 1'b1;
    logic [2:0] wait_cnt = 3'd0;
    logic       ready_out;

    int  n_checks = 0;
    int  n_errors = 0;
    int  sel_cnt  = 0;
    bit  prev_merged = 1'b0;
    bit  have_last = 1'b0;
    logic last_out;
    string cur_req = "R1";

    ready_sync_top dut_i (
        .clk(clk), .rst_n(rst_n), .rdy_a(rdy_a), .en_a_n(en_a_n),
        .rdy_b(rdy_b), .en_b_n(en_b_n), .two_stage(two_stage),
        .dev_sel_n(dev_sel_n), .wait_cnt(wait_cnt), .ready_out(ready_out)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: ready_out=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // One period: drive after the rising edge, probe R7 before the falling
    // edge, compare with the model after it, then advance the model.
    task automatic step(input logic r, input logic a, input logic ea_n,
                        input logic b, input logic eb_n, input logic two,
                        input logic sel_n, input logic [2:0] cnt);
        bit hold, merged, exp;
        @(posedge clk);
        #1;
        rst_n = r; rdy_a = a; en_a_n = ea_n; rdy_b = b; en_b_n = eb_n;
        two_stage = two; dev_sel_n = sel_n; wait_cnt = cnt;
        #7;
        if (have_last) check("R7", ready_out, last_out);
        #7;
        hold   = !sel_n && cnt != 3'd0 && sel_cnt < int'(cnt);
        merged = (a && !ea_n && !hold) || (b && !eb_n);
        exp    = !r ? 1'b0 : (two ? prev_merged : merged);
        check(cur_req, ready_out, exp);
        last_out  = ready_out;
        have_last = 1'b1;
        prev_merged = r ? merged : 1'b0;
        sel_cnt = (!r || sel_n) ? 0 : sel_cnt + 1;
    endtask

    initial begin
        #3_000_000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        // R1: reset holds ready low even with both sources enabled high.
        cur_req = "R1";
        for (int i = 0; i < 3; i++) step(0, 1, 0, 1, 0, 0, 1, 3'd0);
        for (int tw = 0; tw < 2; tw++) begin
            // R2, R3, R4 in one-stage (R5) then two-stage (R6) mode.
            for (int pat = 0; pat < 16; pat++) begin
                cur_req = (tw == 0) ? "R5" : "R6";
                if (pat[1:0] == 2'b01) cur_req = "R2";
                if (pat[3:2] == 2'b01) cur_req = "R3";
                if (pat == 4'b0000 || pat == 4'b1010) cur_req = "R4";
                step(1, pat[0], pat[1], pat[2], pat[3], tw[0], 1, 3'd0);
            end
            // R8, R9, R10: each count, selected ten periods, then reload.
            for (int c = 0; c < 8; c++) begin
                cur_req = (c == 0) ? "R9" : "R8";
                for (int k = 0; k < 10; k++) step(1, 1, 0, 0, 1, tw[0], 0, 3'(c));
                step(1, 1, 0, 0, 1, tw[0], 1, 3'(c));
                cur_req = "R10";
                for (int k = 0; k < 9; k++) step(1, 1, 0, 0, 1, tw[0], 0, 3'(c));
                step(1, 1, 0, 0, 1, tw[0], 1, 3'(c));
            end
            // R11: source B overlaps a running wait count, then drops.
            cur_req = "R11";
            for (int k = 0; k < 3; k++) step(1, 1, 0, 1, 0, tw[0], 0, 3'd6);
            for (int k = 0; k < 6; k++) step(1, 1, 0, 0, 0, tw[0], 0, 3'd6);
            step(1, 1, 0, 1, 0, tw[0], 1, 3'd6);
        end
        // R1: reset in the middle of a selection restarts the count.
        cur_req = "R1";
        step(1, 1, 0, 0, 1, 0, 0, 3'd4);
        step(0, 1, 0, 0, 1, 0, 0, 3'd4);
        cur_req = "R8";
        for (int k = 0; k < 6; k++) step(1, 1, 0, 0, 1, 0, 0, 3'd4);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule